// File: doc/BRIEF.md
# Serial Deserializer with Bit-Slip Word Alignment

The block turns a single-rate serial bit stream into parallel words of `W` bits (eight by default). Every rising edge of a fast clock samples one bit. Every rising edge of a divided clock, which runs at 1/`W` of the fast rate and is phase-aligned with it, delivers one word on the parallel output. In each word the earliest received bit sits in the most significant position.

Downstream framing logic aligns the word boundary to a known training pattern. It does this by pulsing a slip request. Each accepted request moves the capture window one bit earlier in the stream. On a repeating pattern this shows up as a one-position right rotation of the word. A status output carries the window offset that belongs to the word currently on the parallel output. The slip feature can be removed at build time with a parameter.

A small state machine in the divided-clock domain controls slip acceptance. It has three states:
- FILL: the history register is being loaded after reset.
- ARMED: a slip request is accepted.
- COOL: a request was just taken, and the slip input must go low before another is accepted.

The transitions are:
- FILL→ARMED after two divided-clock edges.
- ARMED→COOL when a request is taken.
- COOL→ARMED on the first divided-clock edge that sees the slip input low.

Top module: `slip_deser`

## Requirements
- R1: On each divided-clock edge the block captures `W` consecutive bits sampled on fast-clock edges. The word appears on `word_out` with the earliest bit in bit `W-1`. At offset 0 the newest bit in the window is the one sampled one fast edge before the capturing divided edge.
- R2: While `rst` is high, `word_out` and `slip_pos` are zero.
- R3: After `rst` falls, `word_out` stays zero through the first three divided-clock edges. The fourth edge shows the first real word.
- R4: A slip request seen in state ARMED raises the offset by one modulo `W`. This moves the window one bit earlier in the stream. With the repeating pattern 1001_0011, offset 1 gives 1100_1001 and offset 2 gives 1110_0100.
- R5: A slip input that stays high on consecutive divided-clock edges counts once. A second request is accepted only after at least one low cycle.
- R6: If a request is captured on divided-clock edge N, the shifted word and the new `slip_pos` first appear after edge N+2. After edges N and N+1 the old alignment is still shown.
- R7: After `W` accepted slips, the offset and the word return to the original alignment.
- R8: With `SLIP_EN` = 0, the slip input has no effect. `slip_pos` stays 0 and words keep offset 0.
- R9: Slip requests seen while in state FILL are ignored.
- R10: `slip_pos` always equals the offset used to capture the word currently on `word_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Fast bit clock, one bit per rising edge |
| clk_div | input | 1 | Divided word clock, 1/W of clk_ser, phase-aligned |
| rst | input | 1 | Synchronous active-high reset, applied in both domains |
| ser_in | input | 1 | Serial data bit |
| slip | input | 1 | Slip request, sampled on clk_div |
| word_out | output | W | Parallel word, earliest bit in MSB |
| slip_pos | output | $clog2(W) | Window offset belonging to the current word |

## Verification
The bench builds two copies of the block with the default width of 8. One copy has `SLIP_EN` = 1 and the other has `SLIP_EN` = 0, and both are driven by the same stimulus. This lets every slip scenario show the accepted rotation on one copy and the absence of any effect on the other.

With width 8, a full cycle of offsets takes only eight pulses. The bench therefore sweeps every offset, including the wrap back to zero, under a periodic pattern and again under an arithmetic pseudo-random stream. It computes each expected word from the bit index of the stream.

Separate short sequences cover the following cases:
- the reset fill window;
- the exact two-edge latency of a request;
- requests held high for two and three cycles;
- two requests separated by a single low cycle.

// File: rtl/slip_deser_pkg.sv
`timescale 1ns/1ps
package slip_deser_pkg;
    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COOL  = 2'd2
    } slip_state_e;

    localparam int FILL_EDGES = 2;
    localparam int PIPE_LAT   = 2;
endpackage

// File: rtl/slip_deser_hist.sv
`timescale 1ns/1ps
module slip_deser_hist #(
    parameter int W = 8
) (
    input  logic              clk_ser,
    input  logic              rst,
    input  logic              ser_in,
    output logic [2*W-2:0]    hist
);
    localparam int HW = 2*W - 1;

    // newest bit enters at bit 0; older bits move toward the MSB
    always_ff @(posedge clk_ser) begin
        if (rst) begin
            hist <= '0;
        end else begin
            hist <= {hist[HW-2:0], ser_in};
        end
    end
endmodule

// File: rtl/slip_deser_ctrl.sv
`timescale 1ns/1ps
module slip_deser_ctrl
    import slip_deser_pkg::*;
#(
    parameter int W       = 8,
    parameter bit SLIP_EN = 1'b1,
    localparam int OW     = $clog2(W)
) (
    input  logic          clk_div,
    input  logic          rst,
    input  logic          slip,
    output logic          live,
    output logic [OW-1:0] ofs
);
    localparam logic [OW-1:0] ONE_STEP = OW'(1);
    localparam logic [1:0]    FILL_LAST = 2'(FILL_EDGES - 1);

    slip_state_e st, st_nx;
    logic [1:0]  fill_cnt;
    logic        req;
    logic        take;

    generate
        if (SLIP_EN) begin : g_slip_on
            assign req = slip;
        end else begin : g_slip_off
            assign req = 1'b0;
            // R8: with the feature removed the offset never leaves zero
            p_no_slip_r8: assert property (@(posedge clk_div) disable iff (rst)
                ofs == '0);
        end
    endgenerate

    // state register
    always_ff @(posedge clk_div) begin
        if (rst) begin
            st <= ST_FILL;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_FILL:  if (fill_cnt == FILL_LAST) st_nx = ST_ARMED;
            ST_ARMED: if (req)                   st_nx = ST_COOL;
            ST_COOL:  if (!slip)                 st_nx = ST_ARMED;
            default:                             st_nx = ST_FILL;
        endcase
    end

    assign take = (st == ST_ARMED) && req;
    assign live = (st != ST_FILL);

    // outputs: fill counter and offset
    always_ff @(posedge clk_div) begin
        if (rst) begin
            fill_cnt <= '0;
            ofs      <= '0;
        end else begin
            if (st == ST_FILL) fill_cnt <= fill_cnt + 2'd1;
            if (take)          ofs      <= ofs + ONE_STEP;
        end
    end

    // R4: the offset only ever moves forward by one, wrapping (R7)
    p_ofs_step_r4: assert property (@(posedge clk_div) disable iff (rst)
        (ofs != $past(ofs)) |-> (ofs == $past(ofs) + ONE_STEP));

    // R5: no request is taken in the cycle after one was taken
    p_cool_hold_r5: assert property (@(posedge clk_div) disable iff (rst)
        (st == ST_COOL) |=> $stable(ofs));

    // R9: nothing changes the offset during fill
    p_fill_hold_r9: assert property (@(posedge clk_div) disable iff (rst)
        (st == ST_FILL) |=> (ofs == '0));
endmodule

// File: rtl/slip_deser_pipe.sv
`timescale 1ns/1ps
module slip_deser_pipe
    import slip_deser_pkg::*;
#(
    parameter int W   = 8,
    localparam int OW = $clog2(W)
) (
    input  logic          clk_div,
    input  logic          rst,
    input  logic          live,
    input  logic [OW-1:0] ofs,
    input  logic [2*W-2:0] hist,
    output logic [W-1:0]  word_out,
    output logic [OW-1:0] slip_pos
);
    logic [W-1:0]  win;
    logic [W-1:0]  word_q [PIPE_LAT];
    logic [OW-1:0] pos_q  [PIPE_LAT];

    assign win = hist[ofs +: W];

    always_ff @(posedge clk_div) begin
        if (rst) begin
            for (int s = 0; s < PIPE_LAT; s++) begin
                word_q[s] <= '0;
                pos_q[s]  <= '0;
            end
        end else begin
            word_q[0] <= live ? win : '0;
            pos_q[0]  <= ofs;
            for (int s = 1; s < PIPE_LAT; s++) begin
                word_q[s] <= word_q[s-1];
                pos_q[s]  <= pos_q[s-1];
            end
        end
    end

    assign word_out = word_q[PIPE_LAT-1];
    assign slip_pos = pos_q[PIPE_LAT-1];

    // R6/R10: status lags the control offset by exactly two word edges
    p_pos_lag_r10: assert property (@(posedge clk_div) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (slip_pos == $past(ofs, 2)));

    // R3: while the controller is filling, the output stays clear
    p_fill_zero_r3: assert property (@(posedge clk_div) disable iff (rst)
        (!live && !$past(rst)) |=> (word_out == '0));
endmodule

// File: rtl/slip_deser.sv
`timescale 1ns/1ps
module slip_deser #(
    parameter int W       = 8,
    parameter bit SLIP_EN = 1'b1,
    localparam int OW     = $clog2(W)
) (
    input  logic          clk_ser,
    input  logic          clk_div,
    input  logic          rst,
    input  logic          ser_in,
    input  logic          slip,
    output logic [W-1:0]  word_out,
    output logic [OW-1:0] slip_pos
);
    logic [2*W-2:0] hist;
    logic           live;
    logic [OW-1:0]  ofs;

    slip_deser_hist #(.W(W)) u_hist (
        .clk_ser (clk_ser),
        .rst     (rst),
        .ser_in  (ser_in),
        .hist    (hist)
    );

    slip_deser_ctrl #(.W(W), .SLIP_EN(SLIP_EN)) u_ctrl (
        .clk_div (clk_div),
        .rst     (rst),
        .slip    (slip),
        .live    (live),
        .ofs     (ofs)
    );

    slip_deser_pipe #(.W(W)) u_pipe (
        .clk_div  (clk_div),
        .rst      (rst),
        .live     (live),
        .ofs      (ofs),
        .hist     (hist),
        .word_out (word_out),
        .slip_pos (slip_pos)
    );
endmodule

// File: tb/slip_deser_tb.sv
`timescale 1ns/1ps
module slip_deser_tb;
    localparam int W  = 8;
    localparam int OW = 3;
    localparam logic [7:0] PAT = 8'b1001_0011;

    logic clk_ser = 1'b0;
    logic clk_div = 1'b0;
    logic rst = 1'b1;
    logic ser_in = 1'b0;
    logic slip = 1'b0;
    logic [W-1:0]  word_on, word_off;
    logic [OW-1:0] pos_on, pos_off;

    int n_run = 0;
    int n_fail = 0;
    int mode = 0;
    int gdiv = 0;
    int nfast = 0;
    int ph = 0;
    int kexp = 0;
    bit done = 1'b0;

    slip_deser #(.W(W), .SLIP_EN(1'b1)) u_dut (
        .clk_ser(clk_ser), .clk_div(clk_div), .rst(rst), .ser_in(ser_in),
        .slip(slip), .word_out(word_on), .slip_pos(pos_on));

    slip_deser #(.W(W), .SLIP_EN(1'b0)) u_dut_off (
        .clk_ser(clk_ser), .clk_div(clk_div), .rst(rst), .ser_in(ser_in),
        .slip(slip), .word_out(word_off), .slip_pos(pos_off));

    function automatic logic bit_at(int j);
        int v;
        if (mode == 0) return PAT[7 - (j % 8)];
        v = j * 1103515245 + 12345;
        return v[16] ^ v[9];
    endfunction

    // word captured one word-edge before the current gdiv, offset k
    function automatic logic [7:0] wexp(int k);
        logic [7:0] r;
        for (int i = 0; i < W; i++) r[i] = bit_at(8*gdiv - 17 - k - i);
        return r;
    endfunction

    // 200 MHz bit clock; word clock rises every eighth bit edge
    initial begin
        ser_in = bit_at(0);
        forever begin
            #2.5;
            clk_ser = 1'b1;
            if (ph == 0) begin
                clk_div = 1'b1;
                gdiv = gdiv + 1;
            end else if (ph == 4) begin
                clk_div = 1'b0;
            end
            ph = (ph + 1) % 8;
            nfast = nfast + 1;
            #2.5;
            clk_ser = 1'b0;
            ser_in = bit_at(nfast);
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(negedge clk_div);
            #1;
        end
    endtask

    task automatic check_all(string req);
        chk(req, word_on, wexp(kexp));
        chk(req, 8'(pos_on), 8'(kexp));
        chk({req, "/R8"}, word_off, wexp(0));
        chk({req, "/R8"}, 8'(pos_off), 8'd0);
    endtask

    task automatic pulse(int len);
        slip = 1'b1;
        step(len);
        slip = 1'b0;
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step(4);
        // R2: reset state
        chk("R2", word_on, 8'd0);
        chk("R2", 8'(pos_on), 8'd0);
        // release reset with a slip held through the fill edges (R9)
        rst = 1'b0;
        slip = 1'b1;
        step(1);
        chk("R3", word_on, 8'd0);
        step(1);
        chk("R3", word_on, 8'd0);
        slip = 1'b0;
        step(1);
        chk("R3", word_on, 8'd0);
        step(1);
        chk("R1", word_on, PAT);
        chk("R9", 8'(pos_on), 8'd0);
        step(2);
        check_all("R9");

        // offset sweep over both stream patterns, R1 R4 R7
        for (int m = 0; m < 2; m++) begin
            mode = m;
            step(4);
            check_all("R1");
            for (int s = 1; s <= 8; s++) begin
                pulse(1);
                kexp = (kexp + 1) % 8;
                step(4);
                check_all(s == 8 ? "R7" : "R4");
                if (m == 0 && s == 1) chk("R4", word_on, 8'b1100_1001);
                if (m == 0 && s == 2) chk("R4", word_on, 8'b1110_0100);
                if (s == 8) chk("R7", 8'(pos_on), 8'd0);
            end
        end

        // R6 latency: request seen on edge N, new word after edge N+2
        mode = 0;
        step(4);
        pulse(1);
        chk("R6", word_on, wexp(kexp));
        chk("R6", 8'(pos_on), 8'(kexp));
        step(1);
        chk("R6", word_on, wexp(kexp));
        chk("R6", 8'(pos_on), 8'(kexp));
        kexp = (kexp + 1) % 8;
        step(1);
        chk("R6", word_on, wexp(kexp));
        chk("R10", 8'(pos_on), 8'(kexp));

        // R5: held requests count once, a low gap re-arms
        step(3);
        pulse(2);
        kexp = (kexp + 1) % 8;
        step(4);
        check_all("R5");
        pulse(3);
        kexp = (kexp + 1) % 8;
        step(4);
        check_all("R5");
        pulse(1);
        step(1);
        pulse(1);
        kexp = (kexp + 2) % 8;
        step(4);
        check_all("R5");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule